// File: doc/BRIEF.md
# Data ALU Late-State Hazard Interlock

This block sits beside the issue stage of a DSP core and keeps a record of one bit of data-ALU history: whether the ALU is running in Normal or Late execution mode. Multiply-class and multi-bit shift operations leave their results late, so the ALU enters Late mode. It stays there until a non-ALU instruction, or a multi-cycle ALU instruction other than a long-word shift, returns it to Normal. Ordinary ALU operations leave the mode as it is. An ALU operation that runs while the mode is Late therefore also produces a late result.

The issue logic presents each instruction as a set of pre-decoded class flags, its source and destination register identifiers, a valid flag, and an advance enable from the rest of the pipeline. The block requests a single-cycle stall in three cases, each only when the instruction directly before it was an ALU operation that ran in Late mode. The first case is a move that reads that operation's destination. The second is a two-stage operation that uses that destination as a multiply or shift operand. The third is any instruction that reads the condition codes. Arithmetic, logic and accumulate consumers of a late result never stall.

Top module: `alu_late_interlock`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `alu_late` is 0 (Normal) and `stall` is 0.
- R2: An advancing instruction with `op_alu`=1 and `op_two_stage`=1 sets `alu_late` to 1 from the next cycle.
- R3: An advancing instruction with `op_alu`=1 and `op_long_shift`=1 sets `alu_late` to 1, even when `op_multi_cycle`=1.
- R4: An advancing instruction with `op_alu`=0 clears `alu_late` to 0. So does one with `op_alu`=1 and `op_multi_cycle`=1 but `op_long_shift`=0.
- R5: An advancing ALU instruction with none of `op_two_stage`, `op_multi_cycle` or `op_long_shift` set leaves `alu_late` unchanged.
- R6: `stall` is 1 when the instruction presented has `use_move_src`=1 and a valid source whose id equals the valid destination of the immediately preceding advanced ALU instruction, and that instruction ran in Late mode (`alu_late`=1 after it).
- R7: Under the same producer condition, a consumer with `op_two_stage`=1 and `use_mul_src`=1 whose valid source matches stalls. A consumer without those flags, such as an accumulate or an add, does not stall. Neither does one with `use_mul_src`=1 but `op_two_stage`=0.
- R8: Under the same producer condition, a consumer with `use_cc`=1 stalls whatever its register ids are.
- R9: A stall lasts exactly one cycle. `alu_late` does not change during it. In the following cycle the same instruction advances without a second stall.
- R10: There is no stall when ids differ, when the source valid bit or the producer's `dst_vld` is 0, when the producer ran in Normal mode, or when an empty issue cycle separates the producer from the consumer.
- R11: `stall` is 1 only when `in_valid`=1 and `advance`=1. While `advance`=0 neither the mode nor the producer record changes. A cycle with `advance`=1 and `in_valid`=0 leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented at issue |
| advance | input | 1 | Pipeline may move this cycle |
| op_alu | input | 1 | Instruction executes in the data ALU |
| op_two_stage | input | 1 | Multiply or multi-bit shift (two-stage) op |
| op_multi_cycle | input | 1 | Multi-cycle instruction |
| op_long_shift | input | 1 | Long-word multi-bit shift |
| use_move_src | input | 1 | Sources are read by a move |
| use_mul_src | input | 1 | Sources feed a multiplier or shifter operand |
| use_cc | input | 1 | Instruction reads condition codes |
| src_vld | input | NUM_SRC | Per-source valid bits |
| src_ids | input | NUM_SRC*REG_W | Source ids, source k in bits [k*REG_W +: REG_W] |
| dst_vld | input | 1 | Destination id is valid |
| dst_id | input | REG_W | Destination register id |
| stall | output | 1 | One-cycle interlock request |
| alu_late | output | 1 | Current mode, 1 = Late |

## Verification
The assertions check the relations that hold in every cycle. A stall never lasts two cycles. The mode is frozen across a stall and across any cycle in which no instruction advances. A stall only happens with a valid, advancing instruction while the mode is Late. Non-ALU, two-stage and long-shift instructions drive the mode the way R2 to R4 require. Which consumer kinds stall, the register match and its valid bits, and the adjacency rule all depend on instruction sequences. Only the bench's scenarios show those, and it checks them against its own cycle model on every clock.

// File: rtl/alu_ilk_pkg.sv
package alu_ilk_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LATE   = 1'b1
    } alu_mode_e;

    // pre-decoded class of the issuing instruction
    typedef struct packed {
        logic is_alu;
        logic two_stage;
        logic multi_cycle;
        logic long_shift;
        logic move_src;
        logic mul_src;
        logic cc_use;
    } iclass_t;

endpackage

// File: rtl/alu_mode_next.sv
module alu_mode_next
    import alu_ilk_pkg::*;
(
    input  alu_mode_e cur_mode,
    input  iclass_t   icls,
    output alu_mode_e nxt_mode
);
    always_comb begin
        nxt_mode = cur_mode;
        if (!icls.is_alu) begin
            nxt_mode = MODE_NORMAL;
        end else if (icls.long_shift || icls.two_stage) begin
            nxt_mode = MODE_LATE;
        end else if (icls.multi_cycle) begin
            nxt_mode = MODE_NORMAL;
        end
    end
endmodule

// File: rtl/src_match.sv
module src_match #(
    parameter int NUM_SRC = 2,
    parameter int REG_W   = 4
) (
    input  logic [NUM_SRC-1:0]       src_vld,
    input  logic [NUM_SRC*REG_W-1:0] src_ids,
    input  logic                     prod_vld,
    input  logic [REG_W-1:0]         prod_dst,
    output logic                     hit
);
    logic [NUM_SRC-1:0] hit_vec;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        assign hit_vec[g] = src_vld[g] && prod_vld &&
                            (src_ids[g*REG_W +: REG_W] == prod_dst);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/hazard_eval.sv
module hazard_eval
    import alu_ilk_pkg::*;
(
    input  logic    in_valid,
    input  logic    advance,
    input  logic    prod_late,
    input  logic    reg_hit,
    input  iclass_t icls,
    output logic    stall
);
    logic move_dep;
    logic mul_dep;
    logic cc_dep;

    always_comb begin
        move_dep = icls.move_src && reg_hit;
        mul_dep  = icls.two_stage && icls.mul_src && reg_hit;
        cc_dep   = icls.cc_use;
        stall    = in_valid && advance && prod_late &&
                   (move_dep || mul_dep || cc_dep);
    end
endmodule

// File: rtl/alu_late_interlock.sv
module alu_late_interlock
    import alu_ilk_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int REG_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     advance,
    input  logic                     op_alu,
    input  logic                     op_two_stage,
    input  logic                     op_multi_cycle,
    input  logic                     op_long_shift,
    input  logic                     use_move_src,
    input  logic                     use_mul_src,
    input  logic                     use_cc,
    input  logic [NUM_SRC-1:0]       src_vld,
    input  logic [NUM_SRC*REG_W-1:0] src_ids,
    input  logic                     dst_vld,
    input  logic [REG_W-1:0]         dst_id,
    output logic                     stall,
    output logic                     alu_late
);
    typedef struct packed {
        alu_mode_e        mode;
        logic             prod_late;
        logic             prod_vld;
        logic [REG_W-1:0] prod_dst;
    } ilk_state_t;

    ilk_state_t st_d, st_q;
    iclass_t    icls;
    alu_mode_e  mode_nx;
    logic       reg_hit;

    assign icls = '{is_alu:      op_alu,
                    two_stage:   op_two_stage,
                    multi_cycle: op_multi_cycle,
                    long_shift:  op_long_shift,
                    move_src:    use_move_src,
                    mul_src:     use_mul_src,
                    cc_use:      use_cc};

    alu_mode_next u_mode_nx (
        .cur_mode (st_q.mode),
        .icls     (icls),
        .nxt_mode (mode_nx)
    );

    src_match #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_match (
        .src_vld  (src_vld),
        .src_ids  (src_ids),
        .prod_vld (st_q.prod_vld),
        .prod_dst (st_q.prod_dst),
        .hit      (reg_hit)
    );

    hazard_eval u_haz (
        .in_valid  (in_valid),
        .advance   (advance),
        .prod_late (st_q.prod_late),
        .reg_hit   (reg_hit),
        .icls      (icls),
        .stall     (stall)
    );

    always_comb begin
        st_d = st_q;
        if (advance) begin
            if (stall) begin
                // the stall cycle acts as the gap that resolves the hazard
                st_d.prod_late = 1'b0;
            end else if (in_valid) begin
                st_d.mode      = mode_nx;
                st_d.prod_late = op_alu && (mode_nx == MODE_LATE);
                st_d.prod_vld  = dst_vld;
                st_d.prod_dst  = dst_id;
            end else begin
                st_d.prod_late = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alu_late = (st_q.mode == MODE_LATE);
endmodule

// File: rtl/alu_ilk_chk.sv
module alu_ilk_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic advance,
    input logic op_alu,
    input logic op_two_stage,
    input logic op_long_shift,
    input logic stall,
    input logic alu_late
);
    logic fire;
    assign fire = in_valid && advance && !stall;

    // R9
    one_cycle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R9
    stall_mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(alu_late));

    // R11
    stall_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (in_valid && advance));

    // R11
    idle_mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && advance) |=> $stable(alu_late));

    // R4
    non_alu_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !op_alu) |=> !alu_late);

    // R2
    two_stage_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_alu && op_two_stage) |=> alu_late);

    // R3
    long_shift_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_alu && op_long_shift) |=> alu_late);

    // R6
    stall_only_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> alu_late);
endmodule

bind alu_late_interlock alu_ilk_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .advance       (advance),
    .op_alu        (op_alu),
    .op_two_stage  (op_two_stage),
    .op_long_shift (op_long_shift),
    .stall         (stall),
    .alu_late      (alu_late)
);

// File: tb/alu_late_interlock_tb_top.sv
module alu_late_interlock_tb_top;
    localparam int NS = 2;
    localparam int RW = 4;

    typedef struct {
        bit v, alu, two, mc, ls, mv, mul, cc;
        bit s0v, s1v, dv;
        int s0, s1, d;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, advance = 0, op_alu = 0, op_two_stage = 0;
    logic op_multi_cycle = 0, op_long_shift = 0;
    logic use_move_src = 0, use_mul_src = 0, use_cc = 0;
    logic [NS-1:0] src_vld = '0;
    logic [NS*RW-1:0] src_ids = '0;
    logic dst_vld = 0;
    logic [RW-1:0] dst_id = '0;
    logic stall, alu_late;

    int checks = 0;
    int fails = 0;

    // reference model state
    bit m_late = 0;
    bit m_prod = 0;
    bit m_pvld = 0;
    int m_pdst = 0;

    always #5 clk = ~clk;

    alu_late_interlock #(.NUM_SRC(NS), .REG_W(RW)) dut_i (
        .clk, .rst_n, .in_valid, .advance, .op_alu, .op_two_stage,
        .op_multi_cycle, .op_long_shift, .use_move_src, .use_mul_src,
        .use_cc, .src_vld, .src_ids, .dst_vld, .dst_id, .stall, .alu_late
    );

    function automatic ins_t i_blank();
        ins_t r;
        r = '{default: 0};
        r.s0 = 15; r.s1 = 15;
        return r;
    endfunction
    function automatic ins_t i_nop();
        return i_blank();
    endfunction
    function automatic ins_t i_add(int s, int d);
        ins_t r = i_blank();
        r.v = 1; r.alu = 1; r.s0v = 1; r.s0 = s; r.dv = 1; r.d = d;
        return r;
    endfunction
    function automatic ins_t i_mul(int s, int d);
        ins_t r = i_blank();
        r.v = 1; r.alu = 1; r.two = 1; r.mul = 1; r.s0v = 1; r.s0 = s;
        r.dv = 1; r.d = d;
        return r;
    endfunction
    function automatic ins_t i_mov(int s);
        ins_t r = i_blank();
        r.v = 1; r.mv = 1; r.s0v = 1; r.s0 = s;
        return r;
    endfunction
    function automatic ins_t i_bcc();
        ins_t r = i_blank();
        r.v = 1; r.cc = 1;
        return r;
    endfunction
    function automatic ins_t i_mcyc(int d);
        ins_t r = i_blank();
        r.v = 1; r.alu = 1; r.mc = 1; r.dv = 1; r.d = d;
        return r;
    endfunction
    function automatic ins_t i_lshift(int d);
        ins_t r = i_blank();
        r.v = 1; r.alu = 1; r.mc = 1; r.ls = 1; r.dv = 1; r.d = d;
        return r;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(ins_t x, bit adv, string tag);
        bit match, e_stall;
        @(negedge clk);
        in_valid = x.v; advance = adv; op_alu = x.alu; op_two_stage = x.two;
        op_multi_cycle = x.mc; op_long_shift = x.ls; use_move_src = x.mv;
        use_mul_src = x.mul; use_cc = x.cc;
        src_vld = {x.s1v, x.s0v};
        src_ids = {x.s1[RW-1:0], x.s0[RW-1:0]};
        dst_vld = x.dv; dst_id = x.d[RW-1:0];
        match = m_pvld && ((x.s0v && x.s0 == m_pdst) || (x.s1v && x.s1 == m_pdst));
        e_stall = x.v && adv && m_prod &&
                  (x.cc || (x.mv && match) || (x.two && x.mul && match));
        #2;
        check(tag, "stall", int'(stall), int'(e_stall));
        check(tag, "alu_late", int'(alu_late), int'(m_late));
        @(posedge clk);
        if (adv) begin
            if (e_stall) m_prod = 0;
            else if (x.v) begin
                if (!x.alu) m_late = 0;
                else if (x.ls || x.two) m_late = 1;
                else if (x.mc) m_late = 0;
                m_prod = x.alu && m_late;
                m_pvld = x.dv;
                m_pdst = x.d;
            end else m_prod = 0;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        ins_t x;
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", "stall in reset", int'(stall), 0);
        check("R1", "alu_late in reset", int'(alu_late), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(i_nop(), 1, "R1");

        // R5 / R10: add in Normal, then move of its result: no stall
        step(i_add(15, 1), 1, "R5");
        step(i_mov(1), 1, "R10");

        // R2 / R6 / R9 / R4: multiply, dependent move stalls once
        step(i_mul(15, 2), 1, "R2");
        step(i_mov(2), 1, "R6");
        step(i_mov(2), 1, "R9");
        step(i_nop(), 1, "R4");

        // R7 / R5: accumulate consumer no stall, then multiplier consumer stalls
        step(i_mul(15, 3), 1, "R2");
        step(i_add(3, 4), 1, "R7");
        step(i_mul(4, 5), 1, "R7");
        step(i_mul(4, 5), 1, "R9");
        // R7: multiply-source flag without two-stage does not stall
        x = i_add(5, 6); x.mul = 1;
        step(x, 1, "R7");

        // R8: condition-code reader after late ALU op
        step(i_mul(15, 7), 1, "R8");
        x = i_bcc(); x.s0v = 1; x.s0 = 2;
        step(x, 1, "R8");
        step(x, 1, "R9");
        step(i_nop(), 1, "R4");

        // R3 / R10: long shift goes Late, move of other register no stall
        step(i_lshift(6), 1, "R3");
        step(i_mov(7), 1, "R10");

        // R4 / R10: multi-cycle ALU op returns to Normal; no stall after it
        step(i_mul(15, 1), 1, "R2");
        step(i_mcyc(2), 1, "R4");
        step(i_mov(2), 1, "R10");
        step(i_bcc(), 1, "R10");

        // R11 / R10: empty issue cycle separates producer and consumer
        step(i_mul(15, 3), 1, "R2");
        step(i_nop(), 1, "R11");
        step(i_mov(3), 1, "R10");

        // R11: advance low holds everything, then the stall appears
        step(i_mul(15, 3), 1, "R2");
        step(i_mov(3), 0, "R11");
        step(i_mcyc(9), 0, "R11");
        step(i_mov(3), 1, "R6");
        step(i_mov(3), 1, "R9");

        // R10: producer destination invalid
        x = i_mul(15, 8); x.dv = 0;
        step(x, 1, "R10");
        step(i_mov(8), 1, "R10");

        // R10 / R6: source valid bit gating, second source match
        step(i_mul(15, 9), 1, "R2");
        x = i_mov(9); x.s0v = 0;
        step(x, 1, "R10");
        step(i_mul(15, 9), 1, "R2");
        x = i_mov(4); x.s1v = 1; x.s1 = 9;
        step(x, 1, "R6");
        step(x, 1, "R9");
        step(i_nop(), 1, "R11");

        finish_run();
    end
endmodule